// File: doc/BRIEF.md
# Multi-channel UART interrupt aggregator

This block collects the interrupt conditions of four UART channels, plus two device-wide sources (a timer and a general-purpose I/O bank), into one 32-bit read-only status word and a single combined interrupt line. Each source is latched when its event pulse arrives. It stays latched until its own clearing event: a read of a specific register, signalled by a one-cycle read strobe, or, for receive sources, the receive FIFO level falling below its trigger point.

Each channel has a pending flag in the low byte of the word. Each channel also has a 3-bit field that shows the source code of its highest-priority pending condition. The timer and I/O-bank sources appear only in channel 0's field. Software reads the word once to find which channel needs service and why, then reads that channel's register to acknowledge the cause. All pins are plain control and status signals; no stream interface is involved, so there is no back-pressure.

Top module: `uart_irq_aggregator`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `irq_stat` and `irq_o` are all zero.
- R2: Bits [7:4] and [31:20] of `irq_stat` always read zero.
- R3: Bit n of `irq_stat` is channel n's pending flag. Bits [8+3n+2 : 8+3n] hold channel n's source code, so channel 0 is at [10:8] and channel 3 is at [19:17].
- R4: Code 1 is shown while the registered receive level (`rx_at_trig[n]` high) or a latched line-status error is present. The line-status error clears on `ln_stat_rd[n]`.
- R5: A `rx_tmo_pulse[n]` latches a time-out, shown as code 2. It clears in the cycle after `rx_at_trig[n]` goes from 1 to 0. Register reads have no effect on it.
- R6: A `tx_empty_pulse[n]` latches transmit-empty, shown as code 3. It clears on `int_stat_rd[n]`.
- R7: Code 4 is the OR of two latches. The modem/flow delta latch (`mdm_delta_pulse[n]`) clears only on `mdm_stat_rd[n]`. The flow-character latch (`flow_char_pulse[n]`) clears only on `int_stat_rd[n]`.
- R8: The I/O-bank source (code 6, cleared by `gpio_lvl_rd`) and the timer source (code 7, cleared by `tmr_ctl_rd`) appear only in channel 0's field. Channels 1 to 3 never show 5, 6 or 7.
- R9: With several sources pending on one channel, the field shows the first present in this order: 1, 2, 3, 4, 6, 7.
- R10: A channel's pending flag is 1 exactly when its code is non-zero. `irq_o` is the OR of the four pending flags.
- R11: An event pulse and its clearing strobe in the same cycle leave the source latched.
- R12: An input change at a clock edge is visible on `irq_stat` and `irq_o` right after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_at_trig | input | 4 | Per channel: receive FIFO at or above trigger level |
| rx_tmo_pulse | input | 4 | Per channel: receive time-out event |
| ln_err_pulse | input | 4 | Per channel: line-status error event |
| tx_empty_pulse | input | 4 | Per channel: transmitter empty event |
| mdm_delta_pulse | input | 4 | Per channel: modem or flow-control delta event |
| flow_char_pulse | input | 4 | Per channel: Xon/Xoff or special character detected |
| ln_stat_rd | input | 4 | Per channel: line status register read strobe |
| int_stat_rd | input | 4 | Per channel: interrupt status register read strobe |
| mdm_stat_rd | input | 4 | Per channel: modem status register read strobe |
| tmr_evt_pulse | input | 1 | Timer time-out event |
| gpio_evt_pulse | input | 1 | General-purpose I/O bank event |
| tmr_ctl_rd | input | 1 | Timer control register read strobe |
| gpio_lvl_rd | input | 1 | I/O level register read strobe |
| irq_stat | output | 32 | Aggregated status word |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest situations to reach from the ports are those where priority hides a source. A lower-priority condition sits under a higher one, and it must reappear exactly when the higher one is acknowledged. The receive time-out adds a second such case: it can only be cleared through a rise and then a fall of the receive level, never by a read. The stimulus table builds these stacks step by step on single channels and peels them off one read at a time. It also places an event and its acknowledging strobe in the same cycle. The device sources are raised while a different channel is addressed, to show that they land only in channel 0's field.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int CODE_W    = 3;
  localparam int STAT_W    = 32;
  localparam int CODE_BASE = 8;

  typedef enum logic [CODE_W-1:0] {
    SRC_NONE  = 3'd0,
    SRC_RXLS  = 3'd1,
    SRC_RXTMO = 3'd2,
    SRC_TXE   = 3'd3,
    SRC_MDM   = 3'd4,
    SRC_RSVD  = 3'd5,
    SRC_GPIO  = 3'd6,
    SRC_TMR   = 3'd7
  } src_code_e;
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set has precedence so no event is lost against an acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_i) |=> q_o);
  p_set_next_r12: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  p_clr_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/irq_dev_unit.sv
module irq_dev_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic tmr_evt_i,
  input  logic gpio_evt_i,
  input  logic tmr_rd_i,
  input  logic gpio_rd_i,
  output logic tmr_q_o,
  output logic gpio_q_o
);
  irq_src_latch u_tmr (
    .clk(clk), .rst_n(rst_n), .set_i(tmr_evt_i), .clr_i(tmr_rd_i), .q_o(tmr_q_o)
  );
  irq_src_latch u_gpio (
    .clk(clk), .rst_n(rst_n), .set_i(gpio_evt_i), .clr_i(gpio_rd_i), .q_o(gpio_q_o)
  );
endmodule

// File: rtl/irq_chan_unit.sv
module irq_chan_unit
  import irq_agg_pkg::*;
#(
  parameter bit HAS_DEV = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_at_trig_i,
  input  logic              rx_tmo_pulse_i,
  input  logic              ln_err_pulse_i,
  input  logic              tx_empty_pulse_i,
  input  logic              mdm_delta_pulse_i,
  input  logic              flow_char_pulse_i,
  input  logic              ln_stat_rd_i,
  input  logic              int_stat_rd_i,
  input  logic              mdm_stat_rd_i,
  input  logic              dev_gpio_i,
  input  logic              dev_tmr_i,
  output logic [CODE_W-1:0] code_o,
  output logic              pend_o
);
  logic rx_lvl_q;
  logic ls_q, tmo_q, txe_q, mdm_q, fch_q;
  logic gpio_src, tmr_src;
  logic tmo_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_lvl_q <= 1'b0;
    else        rx_lvl_q <= rx_at_trig_i;
  end

  // time-out is acknowledged only by the FIFO level falling below trigger
  assign tmo_clr = rx_lvl_q & ~rx_at_trig_i;

  irq_src_latch u_ls (
    .clk(clk), .rst_n(rst_n), .set_i(ln_err_pulse_i), .clr_i(ln_stat_rd_i), .q_o(ls_q)
  );
  irq_src_latch u_tmo (
    .clk(clk), .rst_n(rst_n), .set_i(rx_tmo_pulse_i), .clr_i(tmo_clr), .q_o(tmo_q)
  );
  irq_src_latch u_txe (
    .clk(clk), .rst_n(rst_n), .set_i(tx_empty_pulse_i), .clr_i(int_stat_rd_i), .q_o(txe_q)
  );
  irq_src_latch u_mdm (
    .clk(clk), .rst_n(rst_n), .set_i(mdm_delta_pulse_i), .clr_i(mdm_stat_rd_i), .q_o(mdm_q)
  );
  irq_src_latch u_fch (
    .clk(clk), .rst_n(rst_n), .set_i(flow_char_pulse_i), .clr_i(int_stat_rd_i), .q_o(fch_q)
  );

  generate
    if (HAS_DEV) begin : g_dev
      assign gpio_src = dev_gpio_i;
      assign tmr_src  = dev_tmr_i;
    end else begin : g_nodev
      assign gpio_src = 1'b0 & dev_gpio_i;
      assign tmr_src  = 1'b0 & dev_tmr_i;
      p_no_dev_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        code_o < CODE_W'(SRC_RSVD));
    end
  endgenerate

  src_code_e code_sel;
  always_comb begin
    if (rx_lvl_q || ls_q)   code_sel = SRC_RXLS;
    else if (tmo_q)         code_sel = SRC_RXTMO;
    else if (txe_q)         code_sel = SRC_TXE;
    else if (mdm_q || fch_q) code_sel = SRC_MDM;
    else if (gpio_src)      code_sel = SRC_GPIO;
    else if (tmr_src)       code_sel = SRC_TMR;
    else                    code_sel = SRC_NONE;
  end

  assign code_o = code_sel;
  assign pend_o = rx_lvl_q | ls_q | tmo_q | txe_q | mdm_q | fch_q | gpio_src | tmr_src;

  p_pend_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o == (code_o != '0));
  p_rx_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ls_q |-> code_o == CODE_W'(SRC_RXLS));
  p_tmo_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_lvl_q && !rx_at_trig_i && !rx_tmo_pulse_i) |=> !tmo_q);
endmodule

// File: rtl/uart_irq_aggregator.sv
module uart_irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] rx_at_trig,
  input  logic [NUM_CH-1:0] rx_tmo_pulse,
  input  logic [NUM_CH-1:0] ln_err_pulse,
  input  logic [NUM_CH-1:0] tx_empty_pulse,
  input  logic [NUM_CH-1:0] mdm_delta_pulse,
  input  logic [NUM_CH-1:0] flow_char_pulse,
  input  logic [NUM_CH-1:0] ln_stat_rd,
  input  logic [NUM_CH-1:0] int_stat_rd,
  input  logic [NUM_CH-1:0] mdm_stat_rd,
  input  logic              tmr_evt_pulse,
  input  logic              gpio_evt_pulse,
  input  logic              tmr_ctl_rd,
  input  logic              gpio_lvl_rd,
  output logic [STAT_W-1:0] irq_stat,
  output logic              irq_o
);
  localparam int CODE_TOP = CODE_BASE + NUM_CH * CODE_W;

  logic              dev_tmr_q, dev_gpio_q;
  logic [NUM_CH-1:0] pend;
  logic [CODE_W-1:0] code [NUM_CH];

  irq_dev_unit u_dev (
    .clk(clk), .rst_n(rst_n),
    .tmr_evt_i(tmr_evt_pulse), .gpio_evt_i(gpio_evt_pulse),
    .tmr_rd_i(tmr_ctl_rd), .gpio_rd_i(gpio_lvl_rd),
    .tmr_q_o(dev_tmr_q), .gpio_q_o(dev_gpio_q)
  );

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      irq_chan_unit #(.HAS_DEV(g == 0)) u_ch (
        .clk(clk), .rst_n(rst_n),
        .rx_at_trig_i(rx_at_trig[g]),
        .rx_tmo_pulse_i(rx_tmo_pulse[g]),
        .ln_err_pulse_i(ln_err_pulse[g]),
        .tx_empty_pulse_i(tx_empty_pulse[g]),
        .mdm_delta_pulse_i(mdm_delta_pulse[g]),
        .flow_char_pulse_i(flow_char_pulse[g]),
        .ln_stat_rd_i(ln_stat_rd[g]),
        .int_stat_rd_i(int_stat_rd[g]),
        .mdm_stat_rd_i(mdm_stat_rd[g]),
        .dev_gpio_i(dev_gpio_q),
        .dev_tmr_i(dev_tmr_q),
        .code_o(code[g]),
        .pend_o(pend[g])
      );
    end
  endgenerate

  always_comb begin
    irq_stat = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      irq_stat[c] = pend[c];
      irq_stat[CODE_BASE + c*CODE_W +: CODE_W] = code[c];
    end
  end

  assign irq_o = |pend;

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_stat[7:NUM_CH] == '0) && (irq_stat[STAT_W-1:CODE_TOP] == '0));
  p_irq_or_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (irq_stat[CODE_TOP-1:CODE_BASE] != '0));
endmodule

// File: tb/uart_irq_aggregator_tb_top.sv
`timescale 1ns/1ps
module uart_irq_aggregator_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] rx_at_trig, rx_tmo_pulse, ln_err_pulse, tx_empty_pulse;
  logic [3:0] mdm_delta_pulse, flow_char_pulse, ln_stat_rd, int_stat_rd, mdm_stat_rd;
  logic tmr_evt_pulse, gpio_evt_pulse, tmr_ctl_rd, gpio_lvl_rd;
  logic [31:0] irq_stat;
  logic irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  uart_irq_aggregator dut_i (
    .clk(clk), .rst_n(rst_n),
    .rx_at_trig(rx_at_trig), .rx_tmo_pulse(rx_tmo_pulse),
    .ln_err_pulse(ln_err_pulse), .tx_empty_pulse(tx_empty_pulse),
    .mdm_delta_pulse(mdm_delta_pulse), .flow_char_pulse(flow_char_pulse),
    .ln_stat_rd(ln_stat_rd), .int_stat_rd(int_stat_rd), .mdm_stat_rd(mdm_stat_rd),
    .tmr_evt_pulse(tmr_evt_pulse), .gpio_evt_pulse(gpio_evt_pulse),
    .tmr_ctl_rd(tmr_ctl_rd), .gpio_lvl_rd(gpio_lvl_rd),
    .irq_stat(irq_stat), .irq_o(irq_o)
  );

  // vector: {ch[26:25], lvl tmo lsr thr msr xch [24:19], lsr_rd isr_rd msr_rd [18:16],
  //          tmr mpio tmr_rd mpio_rd [15:12], codes {c3,c2,c1,c0} [11:0], req tag [30:27]}
  localparam int NV = 35;
  localparam logic [30:0] VEC [NV] = '{
    {4'd6,  2'd0, 13'b000100_000_0000, 3'd0,3'd0,3'd0,3'd3}, // R6 tx empty
    {4'd9,  2'd0, 13'b001000_000_0000, 3'd0,3'd0,3'd0,3'd1}, // R9 line status over tx
    {4'd4,  2'd0, 13'b000000_100_0000, 3'd0,3'd0,3'd0,3'd3}, // R4 lsr read
    {4'd6,  2'd0, 13'b000000_010_0000, 3'd0,3'd0,3'd0,3'd0}, // R6 isr read
    {4'd4,  2'd1, 13'b100000_000_0000, 3'd0,3'd0,3'd1,3'd0}, // R4 rx level
    {4'd9,  2'd1, 13'b110000_000_0000, 3'd0,3'd0,3'd1,3'd0}, // R9 rx over timeout
    {4'd5,  2'd1, 13'b000000_000_0000, 3'd0,3'd0,3'd0,3'd0}, // R5 level fall clears
    {4'd5,  2'd1, 13'b010000_000_0000, 3'd0,3'd0,3'd2,3'd0}, // R5 timeout alone
    {4'd9,  2'd1, 13'b100000_000_0000, 3'd0,3'd0,3'd1,3'd0}, // R9
    {4'd5,  2'd1, 13'b000000_000_0000, 3'd0,3'd0,3'd0,3'd0}, // R5
    {4'd7,  2'd2, 13'b000010_000_0000, 3'd0,3'd4,3'd0,3'd0}, // R7 modem delta
    {4'd7,  2'd2, 13'b000000_010_0000, 3'd0,3'd4,3'd0,3'd0}, // R7 isr read no effect
    {4'd7,  2'd2, 13'b000000_001_0000, 3'd0,3'd0,3'd0,3'd0}, // R7 msr read
    {4'd7,  2'd2, 13'b000001_000_0000, 3'd0,3'd4,3'd0,3'd0}, // R7 flow char
    {4'd7,  2'd2, 13'b000000_001_0000, 3'd0,3'd4,3'd0,3'd0}, // R7 msr read no effect
    {4'd7,  2'd2, 13'b000000_010_0000, 3'd0,3'd0,3'd0,3'd0}, // R7 isr read
    {4'd8,  2'd3, 13'b000000_000_1000, 3'd0,3'd0,3'd0,3'd7}, // R8 timer in ch0 only
    {4'd8,  2'd3, 13'b000000_000_0100, 3'd0,3'd0,3'd0,3'd6}, // R8 mpio over timer
    {4'd8,  2'd3, 13'b000000_000_0001, 3'd0,3'd0,3'd0,3'd7}, // R8 mpio read
    {4'd8,  2'd3, 13'b000000_000_0010, 3'd0,3'd0,3'd0,3'd0}, // R8 timer read
    {4'd11, 2'd3, 13'b000100_010_0000, 3'd3,3'd0,3'd0,3'd0}, // R11 tx + isr read
    {4'd11, 2'd3, 13'b001000_100_0000, 3'd1,3'd0,3'd0,3'd0}, // R11 lsr + lsr read
    {4'd4,  2'd3, 13'b000000_100_0000, 3'd3,3'd0,3'd0,3'd0}, // R4
    {4'd3,  2'd3, 13'b000000_010_0000, 3'd0,3'd0,3'd0,3'd0}, // R3
    {4'd3,  2'd0, 13'b000010_000_0000, 3'd0,3'd0,3'd0,3'd4}, // R3
    {4'd9,  2'd0, 13'b000100_000_0000, 3'd0,3'd0,3'd0,3'd3}, // R9
    {4'd9,  2'd0, 13'b010000_000_0000, 3'd0,3'd0,3'd0,3'd2}, // R9
    {4'd9,  2'd0, 13'b000000_000_0100, 3'd0,3'd0,3'd0,3'd2}, // R9 mpio hidden
    {4'd9,  2'd0, 13'b100000_000_0000, 3'd0,3'd0,3'd0,3'd1}, // R9
    {4'd5,  2'd0, 13'b000000_000_0000, 3'd0,3'd0,3'd0,3'd3}, // R5
    {4'd9,  2'd0, 13'b000000_010_0000, 3'd0,3'd0,3'd0,3'd4}, // R9
    {4'd9,  2'd0, 13'b000000_001_0000, 3'd0,3'd0,3'd0,3'd6}, // R9
    {4'd8,  2'd0, 13'b000000_000_0001, 3'd0,3'd0,3'd0,3'd0}, // R8
    {4'd11, 2'd0, 13'b000000_000_1010, 3'd0,3'd0,3'd0,3'd7}, // R11 timer + read
    {4'd8,  2'd0, 13'b000000_000_0010, 3'd0,3'd0,3'd0,3'd0}  // R8
  };

  function automatic logic [31:0] build(input logic [11:0] c);
    logic [31:0] w = '0;
    for (int k = 0; k < 4; k++) begin
      w[8 + 3*k +: 3] = c[3*k +: 3];
      w[k] = |c[3*k +: 3];
    end
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic clear_pulses();
    rx_tmo_pulse = '0; ln_err_pulse = '0; tx_empty_pulse = '0;
    mdm_delta_pulse = '0; flow_char_pulse = '0;
    ln_stat_rd = '0; int_stat_rd = '0; mdm_stat_rd = '0;
    tmr_evt_pulse = 0; gpio_evt_pulse = 0; tmr_ctl_rd = 0; gpio_lvl_rd = 0;
  endtask

  task automatic apply(input logic [30:0] v);
    int ch = int'(v[26:25]);
    rx_at_trig[ch]      = v[24];
    rx_tmo_pulse[ch]    = v[23];
    ln_err_pulse[ch]    = v[22];
    tx_empty_pulse[ch]  = v[21];
    mdm_delta_pulse[ch] = v[20];
    flow_char_pulse[ch] = v[19];
    ln_stat_rd[ch]      = v[18];
    int_stat_rd[ch]     = v[17];
    mdm_stat_rd[ch]     = v[16];
    tmr_evt_pulse       = v[15];
    gpio_evt_pulse      = v[14];
    tmr_ctl_rd          = v[13];
    gpio_lvl_rd         = v[12];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    rx_at_trig = '0;
    clear_pulses();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset word", irq_stat, 32'h0);
    check("R1 reset irq", {31'b0, irq_o}, 32'h0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      @(posedge clk);
      @(negedge clk);
      clear_pulses();
      // R2 and R3: full word comparison includes reserved bits and layout
      check($sformatf("R%0d vec%0d word", VEC[i][30:27], i), irq_stat, build(VEC[i][11:0]));
      // R10: combined interrupt
      check($sformatf("R10 vec%0d irq", i), {31'b0, irq_o}, {31'b0, |VEC[i][11:0]});
    end

    // R12: nothing visible before the edge, visible right after it
    ln_err_pulse[1] = 1'b1;
    #1;
    check("R12 before edge", irq_stat, 32'h0);
    @(posedge clk);
    @(negedge clk);
    clear_pulses();
    check("R12 after edge", irq_stat, build({3'd0, 3'd0, 3'd1, 3'd0}));

    // R5: a register read does not acknowledge the time-out
    rx_tmo_pulse[2] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clear_pulses();
    ln_stat_rd[2] = 1'b1; int_stat_rd[2] = 1'b1; mdm_stat_rd[2] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clear_pulses();
    check("R5 timeout survives reads", irq_stat, build({3'd0, 3'd2, 3'd1, 3'd0}));

    // R1: asynchronous reset mid-run clears everything
    gpio_evt_pulse = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clear_pulses();
    check("R8 mpio shown", irq_stat, build({3'd0, 3'd2, 3'd1, 3'd6}));
    rst_n = 0;
    #1;
    check("R1 async reset word", irq_stat, 32'h0);
    check("R1 async reset irq", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk);
    @(negedge clk);
    check("R1 stays clear after release", irq_stat, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule